// File: doc/BRIEF.md
# Vector Unit Translation Buffer

A small, fully associative translation buffer owned by a vector execution unit. It maps virtual page numbers to physical frame numbers for the vector memory pipeline. Pages are 512 bytes, so the low nine address bits pass through untranslated. A lookup that hits returns the physical address in the same cycle. A lookup that misses stalls the requester and raises a request toward an external page-table walker. The walker's answer either installs a new entry or is rejected.

Invalidate commands are copies of scalar-side register writes. Three kinds exist: drop one page, drop everything, and a vector-only drop-everything. All three act whether or not the vector unit is enabled. A process context-load event leaves the contents alone. New entries are written only while a vector memory instruction is in progress. When an invalidate and a fill for the same page land in the same cycle, the invalidate wins. Victims are chosen round-robin over eight slots.

Top module: `vec_tlb`

## Requirements
- R1: After reset no entry is valid, `walk_req_o` is low and every lookup misses.
- R2: With `vec_en_i` high, a lookup whose page number matches a valid entry asserts `lk_hit_o` in the same cycle, with `lk_pa_o` = {stored frame, `lk_va_i[8:0]`} and `lk_stall_o` low. At most one entry matches any page.
- R3: A lookup that misses with `vec_en_i` high asserts `lk_stall_o` in the same cycle. If `mem_active_i` is high, `walk_req_o` rises on the next cycle with `walk_vpn_o` equal to `lk_va_i[31:9]`, and both hold until a walker response arrives.
- R4: A response with `walk_rsp_ok_i` high installs the frame, and the page hits from the next cycle. A response with `walk_rsp_ok_i` low installs nothing, pulses `lk_err_o` in that cycle, and drops `walk_req_o` on the next cycle.
- R5: Fills happen only while `mem_active_i` is high. A miss with it low raises no walk request, and a response that arrives while it is low is discarded.
- R6: The buffer holds 8 entries. Each accepted fill goes to a victim slot that starts at 0 and advances by one, modulo 8, per accepted fill. The ninth fill therefore evicts the first.
- R7: `inv_single_i` removes the entry whose page number equals `inv_vpn_i` from the next cycle. Other entries are unaffected.
- R8: `inv_all_i` and `inv_vec_all_i` each clear every entry from the next cycle.
- R9: All invalidates take effect while `vec_en_i` is low.
- R10: `ctx_load_i` has no effect on any entry.
- R11: A fill that coincides with an all-clear, or with a single invalidate of the same page, is discarded and does not advance the victim slot. A single invalidate of a different page does not block the fill.
- R12: With `vec_en_i` low, a lookup neither hits, stalls nor starts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_en_i | input | 1 | Vector unit enabled |
| mem_active_i | input | 1 | Vector memory instruction in progress |
| ctx_load_i | input | 1 | Process context-load event (no effect) |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated physical address |
| lk_stall_o | output | 1 | Lookup missed; requester must hold |
| lk_err_o | output | 1 | Walker rejected the pending fill |
| walk_req_o | output | 1 | Fill request to the walker |
| walk_vpn_o | output | 23 | Page number to be walked |
| walk_rsp_valid_i | input | 1 | Walker response valid |
| walk_rsp_ok_i | input | 1 | Response carries a valid translation |
| walk_rsp_pfn_i | input | 23 | Returned frame number |
| inv_single_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | 23 | Page number to invalidate |
| inv_all_i | input | 1 | Invalidate all entries |
| inv_vec_all_i | input | 1 | Vector-only invalidate all |

## Verification
Hit, physical address, stall and the reject pulse are combinational. The bench samples them one time unit after driving the inputs at the falling edge, with no clock edge in between. `walk_req_o` and `walk_vpn_o` come from a register, so they are checked at the falling edge after the cycle in which the miss was seen. Fills and invalidates update storage at the rising edge they share with the command. Their effect is probed at the following falling edge by a lookup with `mem_active_i` low, which cannot start a new walk. Eviction order is predicted from a count of accepted fills, and the frame values are computed arithmetically from each page number.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  typedef enum logic {
    MC_IDLE = 1'b0,
    MC_WAIT = 1'b1
  } mc_state_e;
endpackage

// File: rtl/vtb_tag_array.sv
module vtb_tag_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 23,
  parameter int PFN_W   = 23,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               hit_o,
  output logic [PFN_W-1:0]   hit_pfn_o,
  input  logic               inv_single_i,
  input  logic [VPN_W-1:0]   inv_vpn_i,
  input  logic               inv_all_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PFN_W-1:0]   wr_pfn_i,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here  = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        pfn_q[g]   <= '0;
      end else begin
        // invalidate first, a surviving fill overrides its own slot
        if (inv_all_i || (inv_single_i && vpn_q[g] == inv_vpn_i))
          valid_q[g] <= 1'b0;
        if (wr_here) begin
          valid_q[g] <= 1'b1;
          vpn_q[g]   <= wr_vpn_i;
          pfn_q[g]   <= wr_pfn_i;
        end
      end
    end

    assert_inv_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_single_i && vpn_q[g] == inv_vpn_i && !wr_here) |=> !valid_q[g]);
  end

  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_pfn_o = hit_pfn_o | pfn_q[i];
  end

  assign hit_o   = |match;
  assign valid_o = valid_q;

  assert_one_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !wr_en_i) |=> (valid_q == '0));
endmodule

// File: rtl/vtb_victim_ptr.sv
module vtb_victim_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (adv_i) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

  assign idx_o = ptr_q;
endmodule

// File: rtl/vtb_miss_fsm.sv
module vtb_miss_fsm
  import vtb_pkg::*;
#(
  parameter int VPN_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic [VPN_W-1:0] miss_vpn_i,
  input  logic             mem_active_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_ok_i,
  input  logic             inv_single_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             inv_all_i,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic             fill_we_o,
  output logic             fill_err_o
);
  mc_state_e        state_q;
  logic [VPN_W-1:0] vpn_q;
  logic             rsp_here;
  logic             kill;

  assign rsp_here   = (state_q == MC_WAIT) && rsp_valid_i;
  assign kill       = inv_all_i || (inv_single_i && inv_vpn_i == vpn_q);
  assign fill_we_o  = rsp_here && rsp_ok_i && mem_active_i && !kill;
  assign fill_err_o = rsp_here && !rsp_ok_i;
  assign walk_req_o = (state_q == MC_WAIT);
  assign walk_vpn_o = vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MC_IDLE;
      vpn_q   <= '0;
    end else begin
      unique case (state_q)
        MC_IDLE: if (miss_i) begin
          state_q <= MC_WAIT;
          vpn_q   <= miss_vpn_i;
        end
        MC_WAIT: if (rsp_valid_i) state_q <= MC_IDLE;
        default: state_q <= MC_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !rsp_valid_i) |=> (walk_req_o && $stable(walk_vpn_o)));
  assert_req_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && rsp_valid_i) |=> !walk_req_o);
endmodule

// File: rtl/vec_tlb.sv
module vec_tlb #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 9,
  parameter int ENTRIES   = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_en_i,
  input  logic             mem_active_i,
  input  logic             ctx_load_i,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_va_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_pa_o,
  output logic             lk_stall_o,
  output logic             lk_err_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             walk_rsp_valid_i,
  input  logic             walk_rsp_ok_i,
  input  logic [PFN_W-1:0] walk_rsp_pfn_i,
  input  logic             inv_single_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             inv_all_i,
  input  logic             inv_vec_all_i
);
  logic               arr_hit;
  logic [PFN_W-1:0]   arr_pfn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim;
  logic               fill_we;
  logic               clear_all;
  logic               lk_act;
  logic               miss_start;
  logic [VPN_W-1:0]   lk_vpn;

  assign lk_vpn     = lk_va_i[VA_W-1:PAGE_BITS];
  assign clear_all  = inv_all_i || inv_vec_all_i;
  assign lk_act     = lk_valid_i && vec_en_i;
  assign lk_hit_o   = lk_act && arr_hit;
  assign lk_stall_o = lk_act && !arr_hit;
  assign lk_pa_o    = {arr_pfn, lk_va_i[PAGE_BITS-1:0]};
  assign miss_start = lk_stall_o && mem_active_i;

  vtb_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_arr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_vpn_i     (lk_vpn),
    .hit_o        (arr_hit),
    .hit_pfn_o    (arr_pfn),
    .inv_single_i (inv_single_i),
    .inv_vpn_i    (inv_vpn_i),
    .inv_all_i    (clear_all),
    .wr_en_i      (fill_we),
    .wr_idx_i     (victim),
    .wr_vpn_i     (walk_vpn_o),
    .wr_pfn_i     (walk_rsp_pfn_i),
    .valid_o      (valid_vec)
  );

  vtb_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_we),
    .idx_o  (victim)
  );

  vtb_miss_fsm #(.VPN_W(VPN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_i       (miss_start),
    .miss_vpn_i   (lk_vpn),
    .mem_active_i (mem_active_i),
    .rsp_valid_i  (walk_rsp_valid_i),
    .rsp_ok_i     (walk_rsp_ok_i),
    .inv_single_i (inv_single_i),
    .inv_vpn_i    (inv_vpn_i),
    .inv_all_i    (clear_all),
    .walk_req_o   (walk_req_o),
    .walk_vpn_o   (walk_vpn_o),
    .fill_we_o    (fill_we),
    .fill_err_o   (lk_err_o)
  );

  assert_ctx_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_load_i && !clear_all && !inv_single_i && !fill_we) |=> $stable(valid_vec));
  assert_fill_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we |-> (mem_active_i && walk_req_o));
  assert_idle_disabled_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_en_i && !walk_req_o) |=> !walk_req_o);
endmodule

// File: tb/vec_tlb_bench.sv
module vec_tlb_bench;
  localparam int VPN_W = 23;
  localparam int PFN_W = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_en = 1'b1, mem_active = 1'b0, ctx_load = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic lk_hit, lk_stall, lk_err, walk_req;
  logic [31:0] lk_pa;
  logic [VPN_W-1:0] walk_vpn;
  logic rsp_valid = 1'b0, rsp_ok = 1'b0;
  logic [PFN_W-1:0] rsp_pfn = '0;
  logic inv_single = 1'b0, inv_all = 1'b0, inv_vec_all = 1'b0;
  logic [VPN_W-1:0] inv_vpn = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_tlb u_vec_tlb (
    .clk_i(clk), .rst_ni(rst_n), .vec_en_i(vec_en), .mem_active_i(mem_active),
    .ctx_load_i(ctx_load), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
    .lk_hit_o(lk_hit), .lk_pa_o(lk_pa), .lk_stall_o(lk_stall), .lk_err_o(lk_err),
    .walk_req_o(walk_req), .walk_vpn_o(walk_vpn), .walk_rsp_valid_i(rsp_valid),
    .walk_rsp_ok_i(rsp_ok), .walk_rsp_pfn_i(rsp_pfn), .inv_single_i(inv_single),
    .inv_vpn_i(inv_vpn), .inv_all_i(inv_all), .inv_vec_all_i(inv_vec_all)
  );

  function automatic logic [VPN_W-1:0] vpn_of(int i);
    return VPN_W'(32'h100 + i * 32'h345);
  endfunction

  function automatic logic [PFN_W-1:0] pfn_of(logic [VPN_W-1:0] v);
    return PFN_W'(v * 5 + 23'h1234);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // lookup with mem_active low: no walk can start
  task automatic probe(string req, logic [VPN_W-1:0] v, logic [8:0] off, bit exp_hit);
    @(negedge clk);
    mem_active = 1'b0; lk_valid = 1'b1; lk_va = {v, off};
    #1;
    check(req, 32'(lk_hit), 32'(exp_hit));
    if (exp_hit) check(req, lk_pa, {pfn_of(v), off});
    lk_valid = 1'b0;
  endtask

  // miss, wait for request, answer; extra commands applied in the response cycle
  task automatic walk(logic [VPN_W-1:0] v, logic [8:0] off, bit ok, bit act_at_rsp,
                      bit do_inv, logic [VPN_W-1:0] iv, bit do_all);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = {v, off}; mem_active = 1'b1;
    #1;
    check("R3 stall", 32'(lk_stall), 32'd1);
    check("R3 nohit", 32'(lk_hit), 32'd0);
    @(negedge clk);
    #1;
    check("R3 walk_req", 32'(walk_req), 32'd1);
    check("R3 walk_vpn", 32'(walk_vpn), 32'(v));
    rsp_valid = 1'b1; rsp_ok = ok; rsp_pfn = pfn_of(v); mem_active = act_at_rsp;
    inv_single = do_inv; inv_vpn = iv; inv_all = do_all;
    #1;
    check("R4 err pulse", 32'(lk_err), 32'(!ok));
    @(negedge clk);
    rsp_valid = 1'b0; inv_single = 1'b0; inv_all = 1'b0; mem_active = 1'b0;
    lk_valid = 1'b0;
    #1;
    check("R4 req dropped", 32'(walk_req), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1 walk_req", 32'(walk_req), 32'd0);
    for (int i = 0; i < 9; i++) probe("R1 empty", vpn_of(i), 9'h0, 1'b0);

    // R2 R4 R6: fill all eight slots, then sweep offsets
    for (int i = 0; i < 8; i++) begin
      walk(vpn_of(i), 9'(i * 37), 1'b1, 1'b1, 1'b0, '0, 1'b0);
      probe("R4 fill visible", vpn_of(i), 9'(i * 37), 1'b1);
    end
    for (int i = 0; i < 8; i++)
      for (int o = 0; o < 512; o += 73) probe("R2 hit pa", vpn_of(i), 9'(o), 1'b1);

    // R6: ninth fill evicts slot 0
    walk(vpn_of(8), 9'h1ff, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    probe("R6 evicted first", vpn_of(0), 9'h0, 1'b0);
    for (int i = 1; i < 9; i++) probe("R6 others kept", vpn_of(i), 9'h5, 1'b1);

    // R10: context load leaves entries
    @(negedge clk); ctx_load = 1'b1;
    @(negedge clk); ctx_load = 1'b0;
    for (int i = 1; i < 9; i++) probe("R10 ctx keeps", vpn_of(i), 9'h11, 1'b1);

    // R7 R9: single invalidate while disabled
    @(negedge clk); vec_en = 1'b0; inv_single = 1'b1; inv_vpn = vpn_of(3);
    @(negedge clk); inv_single = 1'b0; vec_en = 1'b1;
    probe("R7 R9 page removed", vpn_of(3), 9'h0, 1'b0);
    probe("R7 neighbour kept", vpn_of(2), 9'h0, 1'b1);
    probe("R7 neighbour kept", vpn_of(4), 9'h0, 1'b1);

    // R12: disabled lookup does nothing
    @(negedge clk); vec_en = 1'b0; mem_active = 1'b1; lk_valid = 1'b1; lk_va = {vpn_of(4), 9'h3};
    #1;
    check("R12 no hit", 32'(lk_hit), 32'd0);
    check("R12 no stall", 32'(lk_stall), 32'd0);
    @(negedge clk); #1;
    check("R12 no walk", 32'(walk_req), 32'd0);
    lk_valid = 1'b0; mem_active = 1'b0; vec_en = 1'b1;

    // R5: miss with no memory instruction raises no request
    @(negedge clk); lk_valid = 1'b1; lk_va = {vpn_of(0), 9'h0}; mem_active = 1'b0;
    #1; check("R5 stall", 32'(lk_stall), 32'd1);
    @(negedge clk); #1; check("R5 no walk", 32'(walk_req), 32'd0);
    @(negedge clk); #1; check("R5 no walk", 32'(walk_req), 32'd0);
    lk_valid = 1'b0;
    // R5: response after memory instruction ended is dropped
    walk(vpn_of(0), 9'h0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    probe("R5 late rsp dropped", vpn_of(0), 9'h0, 1'b0);

    // R4: rejected response
    walk(vpn_of(0), 9'h0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    probe("R4 reject no entry", vpn_of(0), 9'h0, 1'b0);

    // R11: same-page invalidate beats fill
    walk(vpn_of(0), 9'h0, 1'b1, 1'b1, 1'b1, vpn_of(0), 1'b0);
    probe("R11 fill discarded", vpn_of(0), 9'h0, 1'b0);
    // R11 R6: other-page invalidate; fill goes to slot 1 (evicts page 1)
    walk(vpn_of(0), 9'h40, 1'b1, 1'b1, 1'b1, vpn_of(5), 1'b0);
    probe("R11 fill kept", vpn_of(0), 9'h40, 1'b1);
    probe("R7 other inv", vpn_of(5), 9'h0, 1'b0);
    probe("R6 slot1 evicted", vpn_of(1), 9'h0, 1'b0);
    probe("R6 slot2 kept", vpn_of(2), 9'h0, 1'b1);
    // R11 R8: clear-all with fill
    walk(vpn_of(1), 9'h0, 1'b1, 1'b1, 1'b0, '0, 1'b1);
    for (int i = 0; i < 9; i++) probe("R11 R8 all clear", vpn_of(i), 9'h0, 1'b0);

    // R8 R9: vector-only clear while disabled
    walk(vpn_of(1), 9'h0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    walk(vpn_of(2), 9'h0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    probe("R4 refill", vpn_of(2), 9'h0, 1'b1);
    @(negedge clk); vec_en = 1'b0; inv_vec_all = 1'b1;
    @(negedge clk); inv_vec_all = 1'b0; vec_en = 1'b1;
    probe("R8 R9 vec clear", vpn_of(1), 9'h0, 1'b0);
    probe("R8 R9 vec clear", vpn_of(2), 9'h0, 1'b0);
    // R8 R9: full clear while disabled
    walk(vpn_of(6), 9'h0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    @(negedge clk); vec_en = 1'b0; inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0; vec_en = 1'b1;
    probe("R8 R9 all clear", vpn_of(6), 9'h0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule